// File: doc/BRIEF.md
# Burst Length Equalizer

This block sits between one AXI master and one input port of a round-robin interconnect. Each read or write address request from the master is cut into a sequence of downstream requests whose length never exceeds a configured nominal value. A long burst therefore takes no more of the arbiter's bandwidth per turn than a short one, and masters with different burst habits get equal shares. The block also limits how many downstream sub-transactions may be in flight at a time, separately for reads and writes.

On the return path the block makes the splitting invisible to the master. Read beats are passed straight through, and the last-beat flag is shown to the master only on the final beat of the original burst. On the write side the block inserts a last-beat flag downstream at the end of every sub-burst. It then folds the per-sub-burst write responses into a single response, and that response carries the worst status seen. Requests are treated as incrementing bursts and a single ID, with all responses in order. The nominal length and the in-flight limit are static configuration inputs, and they may change only while the block is idle.

Top module: `eq_top`

## Requirements
- R1: Every downstream read or write request carries a length field (beats minus one) no greater than `cfg_sub_len`.
- R2: An upstream request of L+1 beats with `cfg_sub_len` = S becomes floor(L/(S+1))+1 downstream requests, in order. Each has S+1 beats, except the last, which carries the remaining beats. Sub-burst j starts at the original address plus j*(S+1)*2^size bytes, and the size is forwarded unchanged.
- R3: The number of downstream read sub-bursts accepted but not yet finished by their last data beat never exceeds `cfg_max_out`. Likewise, write sub-bursts accepted but not yet answered by a downstream response never exceed it. Values above MAX_OUT act as MAX_OUT.
- R4: When below the in-flight limit, the first downstream request is presented in the clock cycle right after the upstream address handshake.
- R5: Read data and read status pass to the master unchanged and in order. `s_r_last` is 1 only on the final beat of the original burst.
- R6: Downstream write beats carry the master's data in order, and `m_w_last` is 1 exactly on the last beat of each sub-burst.
- R7: Exactly one write response reaches the master per original write burst. Its status is the numerically largest of the sub-responses (OKAY=00, SLVERR=10, DECERR=11). Intermediate responses are absorbed without raising `s_b_valid`.
- R8: Once a downstream request is presented, it stays valid with unchanged address and length until it is accepted.
- R9: After reset, no downstream request is valid, no response goes to the master, and both upstream address channels are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sub_len | input | 8 | Nominal sub-burst length, beats minus one |
| cfg_max_out | input | CNT_W | In-flight sub-burst limit per direction |
| s_ar_valid | input | 1 | Upstream read request valid |
| s_ar_ready | output | 1 | Upstream read request ready |
| s_ar_addr | input | ADDR_W | Upstream read start address |
| s_ar_len | input | 8 | Upstream read length, beats minus one |
| s_ar_size | input | 3 | Upstream read beat size, log2 bytes |
| s_r_valid | output | 1 | Read data valid to master |
| s_r_ready | input | 1 | Master accepts read data |
| s_r_data | output | DATA_W | Read data to master |
| s_r_resp | output | 2 | Read status to master |
| s_r_last | output | 1 | Final beat of original read burst |
| s_aw_valid | input | 1 | Upstream write request valid |
| s_aw_ready | output | 1 | Upstream write request ready |
| s_aw_addr | input | ADDR_W | Upstream write start address |
| s_aw_len | input | 8 | Upstream write length, beats minus one |
| s_aw_size | input | 3 | Upstream write beat size |
| s_w_valid | input | 1 | Write data valid from master |
| s_w_ready | output | 1 | Write data ready to master |
| s_w_data | input | DATA_W | Write data from master |
| s_b_valid | output | 1 | Merged write response valid |
| s_b_ready | input | 1 | Master accepts write response |
| s_b_resp | output | 2 | Merged write status |
| m_ar_valid | output | 1 | Downstream read sub-request valid |
| m_ar_ready | input | 1 | Downstream read sub-request ready |
| m_ar_addr | output | ADDR_W | Sub-burst read address |
| m_ar_len | output | 8 | Sub-burst read length |
| m_ar_size | output | 3 | Sub-burst read beat size |
| m_r_valid | input | 1 | Downstream read data valid |
| m_r_ready | output | 1 | Downstream read data ready |
| m_r_data | input | DATA_W | Downstream read data |
| m_r_resp | input | 2 | Downstream read status |
| m_r_last | input | 1 | Last beat of a sub-burst |
| m_aw_valid | output | 1 | Downstream write sub-request valid |
| m_aw_ready | input | 1 | Downstream write sub-request ready |
| m_aw_addr | output | ADDR_W | Sub-burst write address |
| m_aw_len | output | 8 | Sub-burst write length |
| m_aw_size | output | 3 | Sub-burst write beat size |
| m_w_valid | output | 1 | Downstream write data valid |
| m_w_ready | input | 1 | Downstream write data ready |
| m_w_data | output | DATA_W | Downstream write data |
| m_w_last | output | 1 | Last beat of a sub-burst |
| m_b_valid | input | 1 | Downstream write response valid |
| m_b_ready | output | 1 | Downstream write response ready |
| m_b_resp | input | 2 | Downstream write status |

## Verification
The hardest case to reach is the in-flight limit. Against a prompt memory model it never binds, so the bench model can withhold all data and responses. While it does, a long burst is issued and the bench confirms that downstream requests stop exactly at the limit. It then releases the model and checks that the rest of the burst completes. Worst-status merging needs mixed sub-responses inside one burst, so the model returns responses from a per-sub-burst plan table. A downstream ready held low shows that a presented request stays unchanged.

// File: rtl/eq_pkg.sv
// Shared types and helpers for the burst length equalizer.
// Assumes the usual 2-bit AXI status encoding.
package eq_pkg;
    typedef logic [1:0] resp_t;
    localparam resp_t RESP_OKAY = 2'b00;
    localparam int    LEN_W     = 8;
    localparam int    SIZE_W    = 3;

    // Pick the more severe of two status codes (larger code is worse).
    function automatic resp_t worst(input resp_t a, input resp_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/eq_fifo.sv
// Small synchronous FIFO used for per-sub-burst side information.
// Assumes push is never issued when full and pop never when empty
// (both are ignored in that case). Output shows the head entry.
module eq_fifo #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [PW:0]      cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/eq_splitter.sv
// Cuts one incrementing address request into sub-requests of at most
// cfg_sub_len+1 beats. Accepts a new request only when idle; the first
// sub-request appears one cycle after acceptance. 'allow' gates new
// presentations; once presented a sub-request is held until accepted.
// Assumes cfg_sub_len is stable while busy.
module eq_splitter import eq_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_sub_len,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [LEN_W-1:0]  up_len,
    input  logic [SIZE_W-1:0] up_size,
    input  logic              allow,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [LEN_W-1:0]  dn_len,
    output logic [SIZE_W-1:0] dn_size,
    output logic              dn_final
);
    logic              busy, held;
    logic [ADDR_W-1:0] addr_q, step;
    logic [LEN_W-1:0]  rem_q;
    logic [SIZE_W-1:0] size_q;

    assign up_ready = !busy;
    assign dn_final = (rem_q <= cfg_sub_len);
    assign dn_len   = dn_final ? rem_q : cfg_sub_len;
    assign dn_addr  = addr_q;
    assign dn_size  = size_q;
    assign dn_valid = busy && (held || allow);
    assign step     = ADDR_W'({1'b0, cfg_sub_len} + 9'd1) << size_q;

    // Request capture, sub-request stepping and hold of a presented request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            held   <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            size_q <= '0;
        end else if (up_valid && up_ready) begin
            busy   <= 1'b1;
            addr_q <= up_addr;
            rem_q  <= up_len;
            size_q <= up_size;
        end else if (dn_valid && dn_ready) begin
            held <= 1'b0;
            if (dn_final) begin
                busy <= 1'b0;
            end else begin
                addr_q <= addr_q + step;
                rem_q  <= rem_q - cfg_sub_len - 1'b1;
            end
        end else if (dn_valid) begin
            held <= 1'b1;
        end
    end
endmodule

// File: rtl/eq_top.sv
// Burst length equalizer top. Splits read and write bursts into
// nominal-length sub-bursts, caps in-flight sub-bursts per direction,
// fixes the read last flag toward the master, inserts write last flags
// downstream and merges write responses (worst status wins).
// Assumes a single ID with in-order responses and incrementing bursts.
module eq_top import eq_pkg::*; #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int MAX_OUT = 4,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_sub_len,
    input  logic [CNT_W-1:0]  cfg_max_out,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [LEN_W-1:0]  s_ar_len,
    input  logic [SIZE_W-1:0] s_ar_size,
    output logic              s_r_valid,
    input  logic              s_r_ready,
    output logic [DATA_W-1:0] s_r_data,
    output logic [1:0]        s_r_resp,
    output logic              s_r_last,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [LEN_W-1:0]  s_aw_len,
    input  logic [SIZE_W-1:0] s_aw_size,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [1:0]        s_b_resp,
    output logic              m_ar_valid,
    input  logic              m_ar_ready,
    output logic [ADDR_W-1:0] m_ar_addr,
    output logic [LEN_W-1:0]  m_ar_len,
    output logic [SIZE_W-1:0] m_ar_size,
    input  logic              m_r_valid,
    output logic              m_r_ready,
    input  logic [DATA_W-1:0] m_r_data,
    input  logic [1:0]        m_r_resp,
    input  logic              m_r_last,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [LEN_W-1:0]  m_aw_len,
    output logic [SIZE_W-1:0] m_aw_size,
    output logic              m_w_valid,
    input  logic              m_w_ready,
    output logic [DATA_W-1:0] m_w_data,
    output logic              m_w_last,
    input  logic              m_b_valid,
    output logic              m_b_ready,
    input  logic [1:0]        m_b_resp
);
    logic [CNT_W-1:0] lim, rd_os, wr_os;
    logic             ar_final, aw_final, rd_allow, wr_allow;
    logic             ar_hs, r_hs, aw_hs, w_hs, b_hs;
    logic             rf_dout, rf_full, rf_empty;
    logic             bf_dout, bf_full, bf_empty, b_fin;
    logic [LEN_W-1:0] wl_dout, w_beat;
    logic             wl_full, wl_empty;
    resp_t            b_acc;

    assign lim   = (cfg_max_out > CNT_W'(MAX_OUT)) ? CNT_W'(MAX_OUT) : cfg_max_out;
    assign ar_hs = m_ar_valid && m_ar_ready;
    assign r_hs  = m_r_valid && m_r_ready;
    assign aw_hs = m_aw_valid && m_aw_ready;
    assign w_hs  = m_w_valid && m_w_ready;
    assign b_hs  = m_b_valid && m_b_ready;

    assign rd_allow = (rd_os < lim) && !rf_full;
    assign wr_allow = (wr_os < lim) && !wl_full && !bf_full;

    eq_splitter #(.ADDR_W(ADDR_W)) u_rd_split (
        .clk(clk), .rst_n(rst_n), .cfg_sub_len(cfg_sub_len),
        .up_valid(s_ar_valid), .up_ready(s_ar_ready), .up_addr(s_ar_addr),
        .up_len(s_ar_len), .up_size(s_ar_size), .allow(rd_allow),
        .dn_valid(m_ar_valid), .dn_ready(m_ar_ready), .dn_addr(m_ar_addr),
        .dn_len(m_ar_len), .dn_size(m_ar_size), .dn_final(ar_final)
    );

    eq_splitter #(.ADDR_W(ADDR_W)) u_wr_split (
        .clk(clk), .rst_n(rst_n), .cfg_sub_len(cfg_sub_len),
        .up_valid(s_aw_valid), .up_ready(s_aw_ready), .up_addr(s_aw_addr),
        .up_len(s_aw_len), .up_size(s_aw_size), .allow(wr_allow),
        .dn_valid(m_aw_valid), .dn_ready(m_aw_ready), .dn_addr(m_aw_addr),
        .dn_len(m_aw_len), .dn_size(m_aw_size), .dn_final(aw_final)
    );

    // Final-sub-burst flags for the read return path.
    eq_fifo #(.WIDTH(1), .DEPTH(MAX_OUT)) u_rd_fin (
        .clk(clk), .rst_n(rst_n), .push(ar_hs), .din(ar_final),
        .pop(r_hs && m_r_last), .dout(rf_dout), .full(rf_full), .empty(rf_empty)
    );

    // Sub-burst lengths for downstream write last insertion.
    eq_fifo #(.WIDTH(LEN_W), .DEPTH(MAX_OUT)) u_wr_len (
        .clk(clk), .rst_n(rst_n), .push(aw_hs), .din(m_aw_len),
        .pop(w_hs && m_w_last), .dout(wl_dout), .full(wl_full), .empty(wl_empty)
    );

    // Final-sub-burst flags for write response merging.
    eq_fifo #(.WIDTH(1), .DEPTH(MAX_OUT)) u_wr_fin (
        .clk(clk), .rst_n(rst_n), .push(aw_hs), .din(aw_final),
        .pop(b_hs), .dout(bf_dout), .full(bf_full), .empty(bf_empty)
    );

    // Read return: pass-through with last flag shown only on the final sub-burst.
    assign s_r_valid = m_r_valid;
    assign m_r_ready = s_r_ready;
    assign s_r_data  = m_r_data;
    assign s_r_resp  = m_r_resp;
    assign s_r_last  = m_r_last && rf_dout && !rf_empty;

    // Write data: released once its sub-burst length is known.
    assign m_w_valid = s_w_valid && !wl_empty;
    assign s_w_ready = m_w_ready && !wl_empty;
    assign m_w_data  = s_w_data;
    assign m_w_last  = (w_beat == wl_dout);

    // Response merge: intermediate responses absorbed, final one forwarded.
    assign b_fin     = bf_dout && !bf_empty;
    assign s_b_valid = m_b_valid && b_fin;
    assign m_b_ready = b_fin ? s_b_ready : 1'b1;
    assign s_b_resp  = worst(b_acc, m_b_resp);

    // In-flight sub-burst counters per direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_os <= '0;
            wr_os <= '0;
        end else begin
            rd_os <= rd_os + CNT_W'(ar_hs) - CNT_W'(r_hs && m_r_last);
            wr_os <= wr_os + CNT_W'(aw_hs) - CNT_W'(b_hs);
        end
    end

    // Beat position inside the current write sub-burst.
    always_ff @(posedge clk) begin
        if (!rst_n)    w_beat <= '0;
        else if (w_hs) w_beat <= m_w_last ? '0 : w_beat + 1'b1;
    end

    // Worst status seen so far in the current write burst.
    always_ff @(posedge clk) begin
        if (!rst_n)    b_acc <= RESP_OKAY;
        else if (b_hs) b_acc <= b_fin ? RESP_OKAY : worst(b_acc, m_b_resp);
    end
endmodule

// File: rtl/eq_chk.sv
// Property checker for eq_top, attached by bind. Keeps its own count of
// in-flight sub-bursts seen at the downstream ports.
module eq_chk #(
    parameter int ADDR_W  = 32,
    parameter int MAX_OUT = 4,
    parameter int CNT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        cfg_sub_len,
    input logic [CNT_W-1:0]  cfg_max_out,
    input logic              s_ar_valid,
    input logic              s_ar_ready,
    input logic              m_ar_valid,
    input logic              m_ar_ready,
    input logic [ADDR_W-1:0] m_ar_addr,
    input logic [7:0]        m_ar_len,
    input logic              m_r_valid,
    input logic              m_r_ready,
    input logic              m_r_last,
    input logic              m_aw_valid,
    input logic              m_aw_ready,
    input logic [ADDR_W-1:0] m_aw_addr,
    input logic [7:0]        m_aw_len,
    input logic              m_b_valid,
    input logic              m_b_ready
);
    logic [7:0] ck_rd, ck_wr;
    logic [7:0] ck_lim;

    assign ck_lim = (int'(cfg_max_out) > MAX_OUT) ? 8'(MAX_OUT) : 8'(cfg_max_out);

    // Independent in-flight counts from port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_rd <= '0;
            ck_wr <= '0;
        end else begin
            ck_rd <= ck_rd + 8'(m_ar_valid && m_ar_ready) - 8'(m_r_valid && m_r_ready && m_r_last);
            ck_wr <= ck_wr + 8'(m_aw_valid && m_aw_ready) - 8'(m_b_valid && m_b_ready);
        end
    end

    a_r1_ar_len: assert property (@(posedge clk) disable iff (!rst_n)
        m_ar_valid |-> (m_ar_len <= cfg_sub_len));
    a_r1_aw_len: assert property (@(posedge clk) disable iff (!rst_n)
        m_aw_valid |-> (m_aw_len <= cfg_sub_len));
    a_r3_rd_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ck_rd <= ck_lim);
    a_r3_wr_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ck_wr <= ck_lim);
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ar_valid && s_ar_ready) |=> (m_ar_valid || ck_rd >= ck_lim));
    a_r8_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ar_valid && !m_ar_ready) |=> (m_ar_valid && $stable(m_ar_addr) && $stable(m_ar_len)));
    a_r8_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_aw_valid && !m_aw_ready) |=> (m_aw_valid && $stable(m_aw_addr) && $stable(m_aw_len)));
endmodule

bind eq_top eq_chk #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_sub_len(cfg_sub_len), .cfg_max_out(cfg_max_out),
    .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready),
    .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr), .m_ar_len(m_ar_len),
    .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_last(m_r_last),
    .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr), .m_aw_len(m_aw_len),
    .m_b_valid(m_b_valid), .m_b_ready(m_b_ready)
);

// File: tb/sim_eq_top.sv
// Self-checking bench for eq_top: a vector table of bursts walked by one
// loop, then directed tests for reset, in-flight limit, status merge and hold.
module sim_eq_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int MO = 4;
    localparam int CW = $clog2(MO + 1);
    localparam int NV = 6;
    // {addr, len (beats-1), size, sub_len}
    localparam logic [50:0] VEC [NV] = '{
        {32'h0000_1000, 8'd15, 3'd2, 8'd3},
        {32'h0000_2000, 8'd9,  3'd2, 8'd3},
        {32'h0000_3000, 8'd2,  3'd3, 8'd7},
        {32'h0000_4000, 8'd0,  3'd0, 8'd3},
        {32'h0000_5000, 8'd31, 3'd1, 8'd0},
        {32'h0000_6000, 8'd7,  3'd2, 8'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [7:0] cfg_sub_len = 8'd3;
    logic [CW-1:0] cfg_max_out = CW'(MO);
    logic s_ar_valid = 0, s_ar_ready; logic [AW-1:0] s_ar_addr = 0; logic [7:0] s_ar_len = 0; logic [2:0] s_ar_size = 0;
    logic s_r_valid, s_r_ready = 1; logic [DW-1:0] s_r_data; logic [1:0] s_r_resp; logic s_r_last;
    logic s_aw_valid = 0, s_aw_ready; logic [AW-1:0] s_aw_addr = 0; logic [7:0] s_aw_len = 0; logic [2:0] s_aw_size = 0;
    logic s_w_valid = 0, s_w_ready; logic [DW-1:0] s_w_data = 0;
    logic s_b_valid, s_b_ready = 1; logic [1:0] s_b_resp;
    logic m_ar_valid, m_ar_ready = 0; logic [AW-1:0] m_ar_addr; logic [7:0] m_ar_len; logic [2:0] m_ar_size;
    logic m_r_valid = 0, m_r_ready; logic [DW-1:0] m_r_data = 0; logic [1:0] m_r_resp = 0; logic m_r_last = 0;
    logic m_aw_valid, m_aw_ready = 0; logic [AW-1:0] m_aw_addr; logic [7:0] m_aw_len; logic [2:0] m_aw_size;
    logic m_w_valid, m_w_ready = 0; logic [DW-1:0] m_w_data; logic m_w_last;
    logic m_b_valid = 0, m_b_ready; logic [1:0] m_b_resp = 0;

    eq_top #(.ADDR_W(AW), .DATA_W(DW), .MAX_OUT(MO)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_sub_len(cfg_sub_len), .cfg_max_out(cfg_max_out),
        .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_addr(s_ar_addr), .s_ar_len(s_ar_len), .s_ar_size(s_ar_size),
        .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_data(s_r_data), .s_r_resp(s_r_resp), .s_r_last(s_r_last),
        .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_addr(s_aw_addr), .s_aw_len(s_aw_len), .s_aw_size(s_aw_size),
        .s_w_valid(s_w_valid), .s_w_ready(s_w_ready), .s_w_data(s_w_data),
        .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_resp(s_b_resp),
        .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr), .m_ar_len(m_ar_len), .m_ar_size(m_ar_size),
        .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_data(m_r_data), .m_r_resp(m_r_resp), .m_r_last(m_r_last),
        .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr), .m_aw_len(m_aw_len), .m_aw_size(m_aw_size),
        .m_w_valid(m_w_valid), .m_w_ready(m_w_ready), .m_w_data(m_w_data), .m_w_last(m_w_last),
        .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_resp(m_b_resp)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;

    // Memory-side model state and logs.
    bit ar_rdy = 1, slv_go = 1;
    int ar_n, aw_n, w_n, up_r_n, sb_n, rq_wr, rq_rd, r_beat, r_total, wdone, b_total;
    int rd_os_max, wr_os_max, first_ar_cyc, ar_hs_cyc;
    logic [1:0] sb_resp;
    logic [7:0] rq_len [64];
    logic [1:0] bplan [64];
    logic [AW-1:0] ar_addr_log [64], aw_addr_log [64];
    logic [7:0] ar_len_log [64], aw_len_log [64];
    logic [2:0] ar_size_log [64];
    logic [DW-1:0] up_data_log [64], w_data_log [64];
    logic up_last_log [64], w_last_log [64];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        ar_n = 0; aw_n = 0; w_n = 0; up_r_n = 0; sb_n = 0; rq_wr = 0; rq_rd = 0;
        r_beat = 0; r_total = 0; wdone = 0; b_total = 0; rd_os_max = 0; wr_os_max = 0;
        first_ar_cyc = -1; ar_hs_cyc = -1; sb_resp = 0;
        for (int i = 0; i < 64; i++) begin rq_len[i] = 0; bplan[i] = 0; end
    endtask

    // Memory model: drive at falling edge, observe handshakes 1 ns later.
    always begin
        @(negedge clk);
        m_ar_ready = ar_rdy;
        m_aw_ready = 1'b1;
        m_w_ready  = 1'b1;
        m_r_valid  = slv_go && (rq_wr > rq_rd);
        m_r_data   = DW'(r_total);
        m_r_resp   = 2'b00;
        m_r_last   = (8'(r_beat) == rq_len[rq_rd[5:0]]);
        m_b_valid  = slv_go && (wdone > b_total);
        m_b_resp   = bplan[b_total[5:0]];
        #1;
        if (m_ar_valid && first_ar_cyc < 0) first_ar_cyc = cyc;
        if (m_ar_valid && m_ar_ready) begin
            ar_addr_log[ar_n[5:0]] = m_ar_addr; ar_len_log[ar_n[5:0]] = m_ar_len;
            ar_size_log[ar_n[5:0]] = m_ar_size; rq_len[rq_wr[5:0]] = m_ar_len;
            rq_wr++; ar_n++;
        end
        if (m_r_valid && m_r_ready) begin
            r_total++;
            if (m_r_last) begin r_beat = 0; rq_rd++; end else r_beat++;
        end
        if (s_r_valid && s_r_ready) begin
            up_data_log[up_r_n[5:0]] = s_r_data; up_last_log[up_r_n[5:0]] = s_r_last; up_r_n++;
        end
        if (m_aw_valid && m_aw_ready) begin
            aw_addr_log[aw_n[5:0]] = m_aw_addr; aw_len_log[aw_n[5:0]] = m_aw_len; aw_n++;
        end
        if (m_w_valid && m_w_ready) begin
            w_data_log[w_n[5:0]] = m_w_data; w_last_log[w_n[5:0]] = m_w_last; w_n++;
            if (m_w_last) wdone++;
        end
        if (m_b_valid && m_b_ready) b_total++;
        if (s_b_valid && s_b_ready) begin sb_n++; sb_resp = s_b_resp; end
        if (ar_n - rq_rd > rd_os_max) rd_os_max = ar_n - rq_rd;
        if (aw_n - b_total > wr_os_max) wr_os_max = aw_n - b_total;
    end

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] l, input logic [2:0] z);
        @(negedge clk);
        s_ar_valid = 1; s_ar_addr = a; s_ar_len = l; s_ar_size = z;
        forever begin
            #1;
            if (s_ar_ready) begin ar_hs_cyc = cyc; break; end
            @(negedge clk);
        end
        @(negedge clk);
        s_ar_valid = 0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] l, input logic [2:0] z);
        @(negedge clk);
        s_aw_valid = 1; s_aw_addr = a; s_aw_len = l; s_aw_size = z;
        forever begin
            #1;
            if (s_aw_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        s_aw_valid = 0;
        for (int k = 0; k <= int'(l); k++) begin
            if (k > 0) @(negedge clk);
            s_w_valid = 1; s_w_data = DW'(k);
            forever begin
                #1;
                if (s_w_ready) break;
                @(negedge clk);
            end
        end
        @(negedge clk);
        s_w_valid = 0;
    endtask

    task automatic wait_reads(input int n);
        int t = 0;
        while (up_r_n < n && t < 3000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        #2;
    endtask

    task automatic wait_bresp();
        int t = 0;
        while (sb_n < 1 && t < 3000) begin @(negedge clk); t++; end
        repeat (6) @(negedge clk);
        #2;
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] va; logic [7:0] vl; logic [2:0] vz; logic [7:0] vs;
        int nsub, s1;
        clr();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R9: idle outputs after reset
        chk(!m_ar_valid && !m_aw_valid, "R9 no downstream request", m_ar_valid, 0);
        chk(!s_r_valid && !s_b_valid, "R9 no response to master", s_b_valid, 0);
        chk(s_ar_ready && s_aw_ready, "R9 address channels ready", s_ar_ready, 1);

        // Vector table: read then write of each burst shape.
        for (int v = 0; v < NV; v++) begin
            {va, vl, vz, vs} = VEC[v];
            s1 = int'(vs) + 1;
            nsub = int'(vl) / s1 + 1;
            cfg_sub_len = vs;
            clr();
            do_read(va, vl, vz);
            wait_reads(int'(vl) + 1);
            chk(ar_n == nsub, "R2 read sub-burst count", ar_n, nsub);
            chk(first_ar_cyc - ar_hs_cyc == 1, "R4 one cycle latency", first_ar_cyc - ar_hs_cyc, 1);
            for (int j = 0; j < nsub; j++) begin
                logic [31:0] ea; int el;
                ea = va + ((32'(j) * 32'(s1)) << vz);
                el = (int'(vl) - j * s1 < int'(vs)) ? int'(vl) - j * s1 : int'(vs);
                chk(ar_addr_log[j] == ea, "R2 read sub address", ar_addr_log[j], ea);
                chk(int'(ar_len_log[j]) == el, "R1 read sub length", ar_len_log[j], el);
                chk(ar_size_log[j] == vz, "R2 read size", ar_size_log[j], vz);
            end
            chk(up_r_n == int'(vl) + 1, "R5 read beat count", up_r_n, int'(vl) + 1);
            for (int k = 0; k <= int'(vl); k++) begin
                chk(up_data_log[k] == DW'(k), "R5 read data", up_data_log[k], k);
                chk(up_last_log[k] == (k == int'(vl)), "R5 read last", up_last_log[k], k == int'(vl));
            end

            clr();
            do_write(va, vl, vz);
            wait_bresp();
            chk(aw_n == nsub, "R2 write sub-burst count", aw_n, nsub);
            for (int j = 0; j < nsub; j++) begin
                logic [31:0] ea; int el;
                ea = va + ((32'(j) * 32'(s1)) << vz);
                el = (int'(vl) - j * s1 < int'(vs)) ? int'(vl) - j * s1 : int'(vs);
                chk(aw_addr_log[j] == ea, "R2 write sub address", aw_addr_log[j], ea);
                chk(int'(aw_len_log[j]) == el, "R1 write sub length", aw_len_log[j], el);
            end
            chk(w_n == int'(vl) + 1, "R6 write beat count", w_n, int'(vl) + 1);
            for (int i = 0; i <= int'(vl); i++) begin
                bit el;
                el = ((i % s1) == int'(vs)) || (i == int'(vl));
                chk(w_last_log[i] == el, "R6 write last position", w_last_log[i], el);
                chk(w_data_log[i] == DW'(i), "R6 write data", w_data_log[i], i);
            end
            chk(sb_n == 1, "R7 one response", sb_n, 1);
            chk(sb_resp == 2'b00, "R7 okay status", sb_resp, 0);
        end

        // R3: in-flight limit with the memory model stalled.
        cfg_sub_len = 8'd3; cfg_max_out = CW'(2);
        clr(); slv_go = 0;
        do_read(32'h8000, 8'd15, 3'd2);
        repeat (10) @(negedge clk); #2;
        chk(ar_n == 2, "R3 read requests stop at limit", ar_n, 2);
        slv_go = 1;
        wait_reads(16);
        chk(ar_n == 4, "R3 read burst completes", ar_n, 4);
        chk(rd_os_max <= 2, "R3 read in-flight peak", rd_os_max, 2);
        clr(); slv_go = 0;
        fork do_write(32'h9000, 8'd15, 3'd2); join_none
        repeat (20) @(negedge clk); #2;
        chk(aw_n == 2, "R3 write requests stop at limit", aw_n, 2);
        slv_go = 1;
        wait_bresp();
        chk(aw_n == 4, "R3 write burst completes", aw_n, 4);
        chk(wr_os_max <= 2, "R3 write in-flight peak", wr_os_max, 2);
        cfg_max_out = CW'(MO);

        // R7: worst-status merge.
        clr(); bplan[1] = 2'b10; bplan[2] = 2'b11;
        do_write(32'hA000, 8'd15, 3'd2);
        wait_bresp();
        chk(sb_n == 1, "R7 single merged response", sb_n, 1);
        chk(sb_resp == 2'b11, "R7 decode error dominates", sb_resp, 3);
        clr(); bplan[2] = 2'b10;
        do_write(32'hA100, 8'd15, 3'd2);
        wait_bresp();
        chk(sb_n == 1, "R7 single merged response", sb_n, 1);
        chk(sb_resp == 2'b10, "R7 slave error kept", sb_resp, 2);

        // R8: presented request held while downstream not ready.
        clr(); ar_rdy = 0;
        fork do_read(32'hB000, 8'd7, 3'd2); join_none
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(m_ar_valid && m_ar_addr == 32'hB000 && m_ar_len == 8'd3,
                "R8 request held", m_ar_addr, 32'hB000);
        end
        ar_rdy = 1;
        wait_reads(8);
        chk(ar_n == 2, "R8 held burst completes", ar_n, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule